// File: doc/BRIEF.md
# Hit Event Memory Packer

This block collects self-triggered discriminator results while an acquisition window is open and ships them out serially once the window has closed. Inside the window a crossing counter numbers every bunch-clock tick. On any tick where at least one threshold comparator of any channel is asserted, one complete event is written into a local store. The event holds the chip identifier, the crossing number and a 2-bit code for every channel, fired or not. No-hit crossings take no storage.

After the window closes, a readout request drains the store over one serial line with a data-valid strobe. Events leave oldest first, back to back, and the store is empty when the last bit has left. If the store fills during a window, later hit crossings are discarded and a full indication stays up until the store has been read out.

Top module: `hit_event_packer`

## Requirements
- R1: After reset `ser_valid` and `mem_full` are low and no readout is running.
- R2: The crossing counter is 0 while `acq_en` is low. Each `bx_tick` seen with `acq_en` high advances it by one. An event stores the counter value of its own crossing, so the first tick of a window is crossing 0.
- R3: An event is written only on a cycle where `bx_tick` and `acq_en` are both high and at least one bit of `thr_hit` is set. Set threshold bits without a tick, and ticks with no bit set, store nothing.
- R4: Channel c owns `thr_hit[3c+2:3c]`. Its 2-bit code is the number of those three bits that are set (0 to 3), whichever bits they are.
- R5: Every event carries the code of all 64 channels, including channels whose code is 0.
- R6: An event is 160 bits, sent MSB first. Bits 159..152 hold `chip_id`, bits 151..128 hold the crossing number, and bits 127..0 hold the channel codes. Channel 63 sits at bits 127..126 and channel 0 at bits 1..0, each code MSB first. `ser_valid` is high for exactly 160 cycles per stored event, with no gap between events.
- R7: Events are read out in the order they were stored.
- R8: The store holds 128 events. `mem_full` is high while 128 events are held. Hit crossings that arrive while the store is full are discarded.
- R9: `ro_start` starts a readout only when `acq_en` is low, no readout is running and the store is not empty. Otherwise it has no effect. The first bit is on `ser_out` in the cycle after `ro_start` is sampled.
- R10: When a readout ends, the store is empty. `mem_full` is low, and a further `ro_start` produces no valid output.
- R11: Ticks with hits that occur while a readout is running are not stored, and they do not disturb the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition window open |
| bx_tick | input | 1 | One-cycle bunch-crossing tick |
| chip_id | input | 8 | Identifier written into each event header |
| thr_hit | input | 192 | Three comparator levels per channel, channel c at bits 3c+2..3c |
| ro_start | input | 1 | Readout request pulse |
| ser_out | output | 1 | Serial event data, MSB first |
| ser_valid | output | 1 | High while `ser_out` carries event bits |
| mem_full | output | 1 | Store holds its maximum number of events |

## Verification
The hardest state to reach is a full store with further hits arriving. It takes 128 separate hit crossings inside one window, each with a different channel pattern and identifier so that order and content can be told apart on readout. The directed fill test issues 130 such crossings, checks the full flag on both sides of the limit, and then drains all 128 frames. A second awkward case is a hit crossing that lands in the middle of a frame. The readout task opens the window and fires a tick partway through a frame, then confirms that the frame is intact and that nothing was added to the store.

// File: rtl/hep_pkg.sv
package hep_pkg;
    parameter int unsigned HEP_CH    = 64;
    parameter int unsigned HEP_THR   = 3;
    parameter int unsigned HEP_CODE  = 2;
    parameter int unsigned HEP_ID_W  = 8;
    parameter int unsigned HEP_BX_W  = 24;
    parameter int unsigned HEP_DEPTH = 128;

    typedef enum logic {
        RO_IDLE  = 1'b0,
        RO_SHIFT = 1'b1
    } ro_state_e;

    // Next index in a circular store of the given depth
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/hep_code_enc.sv
module hep_code_enc #(
    parameter int unsigned NCH = hep_pkg::HEP_CH,
    parameter int unsigned THR = hep_pkg::HEP_THR,
    parameter int unsigned CW  = hep_pkg::HEP_CODE
) (
    input  logic [NCH*THR-1:0] thr,
    output logic [NCH*CW-1:0]  codes,
    output logic               any_hit
);
    localparam int unsigned MAXC = (1 << CW) - 1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CW-1:0] code_g;
        always_comb begin
            int unsigned n;
            n = 0;
            for (int b = 0; b < THR; b++) begin
                n = n + int'(thr[ch*THR + b]);
            end
            code_g = (n > MAXC) ? CW'(MAXC) : CW'(n);
        end
        assign codes[ch*CW +: CW] = code_g;
    end

    assign any_hit = |thr;
endmodule

// File: rtl/hep_bx_counter.sv
module hep_bx_counter #(
    parameter int unsigned BXW = hep_pkg::HEP_BX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acq_en,
    input  logic           bx_tick,
    output logic [BXW-1:0] bx_num
);
    always_ff @(posedge clk) begin
        if (rst || !acq_en) begin
            bx_num <= '0;
        end else if (bx_tick) begin
            bx_num <= bx_num + 1'b1;
        end
    end
endmodule

// File: rtl/hep_event_store.sv
module hep_event_store #(
    parameter int unsigned EW    = 160,
    parameter int unsigned DEPTH = hep_pkg::HEP_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [EW-1:0] wr_data,
    input  logic          pop,
    output logic [EW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    logic [EW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= AW'(hep_pkg::ring_next(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= AW'(hep_pkg::ring_next(int'(rd_ptr), DEPTH));
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
endmodule

// File: rtl/hep_serializer.sv
module hep_serializer #(
    parameter int unsigned EW = 160
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          has_data,
    input  logic [EW-1:0] load_data,
    output logic          pop,
    output logic          ser_out,
    output logic          ser_valid
);
    import hep_pkg::*;

    localparam int unsigned BCW = $clog2(EW);

    ro_state_e      state;
    logic [EW-1:0]  shreg;
    logic [BCW-1:0] bit_idx;
    logic           last_bit;

    assign last_bit = (bit_idx == BCW'(EW - 1));

    always_comb begin
        pop = 1'b0;
        if (state == RO_IDLE) begin
            pop = start && has_data;
        end else if (last_bit) begin
            pop = has_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RO_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
        end else if (pop) begin
            state   <= RO_SHIFT;
            shreg   <= load_data;
            bit_idx <= '0;
        end else if (state == RO_SHIFT) begin
            if (last_bit) begin
                state <= RO_IDLE;
            end
            shreg   <= {shreg[EW-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign ser_out   = (state == RO_SHIFT) && shreg[EW-1];
    assign ser_valid = (state == RO_SHIFT);
endmodule

// File: rtl/hit_event_packer.sv
module hit_event_packer #(
    parameter int unsigned NCH   = hep_pkg::HEP_CH,
    parameter int unsigned THR   = hep_pkg::HEP_THR,
    parameter int unsigned CW    = hep_pkg::HEP_CODE,
    parameter int unsigned IDW   = hep_pkg::HEP_ID_W,
    parameter int unsigned BXW   = hep_pkg::HEP_BX_W,
    parameter int unsigned DEPTH = hep_pkg::HEP_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acq_en,
    input  logic               bx_tick,
    input  logic [IDW-1:0]     chip_id,
    input  logic [NCH*THR-1:0] thr_hit,
    input  logic               ro_start,
    output logic               ser_out,
    output logic               ser_valid,
    output logic               mem_full
);
    localparam int unsigned EW = IDW + BXW + NCH * CW;

    logic [NCH*CW-1:0] codes;
    logic              any_hit;
    logic [BXW-1:0]    bx_num;
    logic              push, pop, empty, full;
    logic [EW-1:0]     rd_data;

    hep_code_enc #(.NCH(NCH), .THR(THR), .CW(CW)) u_enc (
        .thr     (thr_hit),
        .codes   (codes),
        .any_hit (any_hit)
    );

    hep_bx_counter #(.BXW(BXW)) u_bx (
        .clk     (clk),
        .rst     (rst),
        .acq_en  (acq_en),
        .bx_tick (bx_tick),
        .bx_num  (bx_num)
    );

    assign push = acq_en && bx_tick && any_hit && !ser_valid && !full;

    hep_event_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_data ({chip_id, bx_num, codes}),
        .pop     (pop),
        .rd_data (rd_data),
        .empty   (empty),
        .full    (full)
    );

    hep_serializer #(.EW(EW)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .start     (ro_start && !acq_en),
        .has_data  (!empty),
        .load_data (rd_data),
        .pop       (pop),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );

    assign mem_full = full;
endmodule

// File: rtl/hit_event_packer_chk.sv
module hit_event_packer_chk (
    input logic clk,
    input logic rst,
    input logic acq_en,
    input logic ro_start,
    input logic ser_valid,
    input logic mem_full
);
    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_valid && !mem_full));

    // R9
    a_r9_no_start_in_window: assert property (@(posedge clk) disable iff (rst)
        (acq_en && !ser_valid) |=> !ser_valid);

    // R9
    a_r9_start_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_valid) |-> $past(ro_start));

    // R8
    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_full && !ser_valid && !ro_start) |=> mem_full);

    // R10
    a_r10_empty_after_readout: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_valid) |-> !mem_full);
endmodule

bind hit_event_packer hit_event_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_en    (acq_en),
    .ro_start  (ro_start),
    .ser_valid (ser_valid),
    .mem_full  (mem_full)
);

// File: tb/hit_event_packer_bench.sv
module hit_event_packer_bench;
    localparam int NCH = 64;
    localparam int EW  = 160;
    localparam int DEP = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acq_en = 1'b0;
    logic             bx_tick = 1'b0;
    logic [7:0]       chip_id = '0;
    logic [NCH*3-1:0] thr_hit = '0;
    logic             ro_start = 1'b0;
    logic             ser_out, ser_valid, mem_full;

    int checks = 0;
    int fails  = 0;
    int bx_model = 0;
    logic [EW-1:0] exp_q[$];

    always #10 clk = ~clk;

    hit_event_packer u_hit_event_packer (
        .clk       (clk),
        .rst       (rst),
        .acq_en    (acq_en),
        .bx_tick   (bx_tick),
        .chip_id   (chip_id),
        .thr_hit   (thr_hit),
        .ro_start  (ro_start),
        .ser_out   (ser_out),
        .ser_valid (ser_valid),
        .mem_full  (mem_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [EW-1:0] act, input logic [EW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] mk_event(input logic [7:0] id, input int bx,
                                              input logic [NCH*3-1:0] t);
        logic [127:0] c;
        for (int ch = 0; ch < NCH; ch++) begin
            int n = 0;
            for (int b = 0; b < 3; b++) n += int'(t[ch*3+b]);
            c[ch*2 +: 2] = 2'(n);
        end
        return {id, 24'(bx), c};
    endfunction

    function automatic logic [NCH*3-1:0] pat_mix();
        logic [NCH*3-1:0] t;
        for (int ch = 0; ch < NCH; ch++) t[ch*3 +: 3] = 3'(ch % 8);
        return t;
    endfunction

    function automatic logic [NCH*3-1:0] pat_k(input int k);
        logic [NCH*3-1:0] t = '0;
        t[3*(k % 64) +: 3]     = 3'b011;
        t[3*((k + 5) % 64) +: 3] = 3'b100;
        return t;
    endfunction

    task automatic open_win();
        @(negedge clk); acq_en = 1'b1; bx_model = 0;
    endtask

    task automatic close_win();
        @(negedge clk); acq_en = 1'b0;
    endtask

    task automatic tick(input logic [NCH*3-1:0] t, input logic [7:0] id);
        @(negedge clk); thr_hit = t; chip_id = id; bx_tick = 1'b1;
        @(negedge clk); bx_tick = 1'b0; thr_hit = '0;
        if (acq_en && (|t) && exp_q.size() < DEP) exp_q.push_back(mk_event(id, bx_model, t));
        if (acq_en) bx_model++;
    endtask

    // Drains n frames; inject_at >= 0 fires a hit tick inside the readout (R11)
    task automatic run_readout(input int n, input int inject_at, input string req);
        logic [EW-1:0] fr = '0;
        logic [EW-1:0] ex;
        int gaps = 0;
        @(negedge clk); ro_start = 1'b1;
        @(negedge clk); ro_start = 1'b0;
        for (int i = 0; i < n * EW; i++) begin
            if (!ser_valid) gaps++;
            fr = {fr[EW-2:0], ser_out};
            if (i % EW == EW - 1) begin
                ex = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                chk(fr === ex, req, $sformatf("frame %0d content/order", i / EW), fr, ex);
            end
            if (i == inject_at) begin
                acq_en = 1'b1; bx_tick = 1'b1; thr_hit = '1; chip_id = 8'hEE;
            end
            if (i == inject_at + 1) begin
                acq_en = 1'b0; bx_tick = 1'b0; thr_hit = '0;
            end
            @(negedge clk);
        end
        chk(gaps == 0, "R6", "valid gaps during frames", EW'(gaps), '0);
        for (int i = 0; i < 3; i++) begin
            chk(!ser_valid, req, "valid after readout end", EW'(ser_valid), '0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!ser_valid, "R1", "ser_valid after reset", EW'(ser_valid), '0);
        chk(!mem_full, "R1", "mem_full after reset", EW'(mem_full), '0);
    endtask

    task automatic t_basic();
        logic [NCH*3-1:0] one = '0;
        one[0] = 1'b1;
        open_win();
        tick(pat_mix(), 8'hA5);             // R4: every 3-bit combination
        tick('0, 8'hA5);                    // R3: no-hit tick stores nothing
        @(negedge clk); thr_hit = '1;       // R3: hits without a tick
        @(negedge clk); thr_hit = '0;
        tick(one, 8'h3C);                   // R5: single channel, others zero
        tick('1, 8'hC3);                    // R4: all codes 3
        // R9: start while window open has no effect
        @(negedge clk); ro_start = 1'b1;
        @(negedge clk); ro_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!ser_valid, "R9", "start during window", EW'(ser_valid), '0);
            @(negedge clk);
        end
        close_win();
        chk(exp_q.size() == 3, "R3", "bench model event count", EW'(exp_q.size()), EW'(3));
        run_readout(3, -1, "R2 R4 R5 R6 R7");
        run_readout(0, -1, "R10");
    endtask

    task automatic t_busy_capture();
        open_win();
        tick(pat_k(7), 8'h5A);
        close_win();
        run_readout(1, 50, "R11");
        run_readout(0, -1, "R11");
    endtask

    task automatic t_fill();
        open_win();
        for (int k = 0; k < DEP + 2; k++) begin
            tick(pat_k(k), 8'(k));
            if (k == DEP - 2) chk(!mem_full, "R8", "full below capacity", EW'(mem_full), '0);
            if (k == DEP - 1) chk(mem_full, "R8", "full at capacity", EW'(mem_full), EW'(1));
            if (k == DEP + 1) chk(mem_full, "R8", "full after drops", EW'(mem_full), EW'(1));
        end
        close_win();
        @(negedge clk);
        chk(mem_full, "R8", "full held after window", EW'(mem_full), EW'(1));
        run_readout(DEP, -1, "R7 R8 R2");
        chk(!mem_full, "R10", "full cleared after readout", EW'(mem_full), '0);
        run_readout(0, -1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_busy_capture();
        t_fill();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule